// File: doc/BRIEF.md
# Vector Slice Sequencer

This block turns one accepted vector instruction into a stream of register slices and feeds them into an execution pipeline one per cycle. Each vector register is cut into `SLICES` slices. An instruction covers as many slice slots as its widest operand group needs. Slot 0 enters the pipeline in the cycle after acceptance. Each later slot enters only in a cycle where `rd_ok` grants its register reads, so that a dependent instruction can chain on earlier results one slice at a time.

For every slot the read side gives the source register and slice for each vector operand, plus the element offset and count for a memory access. The write side, at the pipeline tail, gives the destination register and slice, the scalar write strobe and the retire pulse. In widening forms the narrow operands are interleaved across the slots: narrow sources take the even slots and a narrow destination takes the odd slots.

Top module: `vslice_seq`

## Requirements
- R1: The slot count is n = 2^max(0, L + W + log2(SLICES)). L is `issue_lmul` read as a 3-bit two's-complement log2 of the group multiplier (range -4..3). W is 1 when either widening flag is set.
- R2: Slot 0 is on the read side (`rd_vld`, `rd_slot`=0) in the cycle after `issue_vld` is accepted. Slots 1..n-1 follow in increasing order, one in each cycle where `rd_ok` is high. `rd_last` marks slot n-1, and no further slot follows.
- R3: `issue_ready` is high out of reset and low while slots of the current instruction remain. While slots remain, a cycle with `rd_ok` low injects nothing, and a request presented while `issue_ready` is low leaves no trace.
- R4: With `PIPELINED`=0, `issue_ready` also requires every pipeline stage to be empty. With `DEPTH`=3, a one-slot instruction keeps it low for three cycles after acceptance.
- R5: An operand mapped directly uses slice index i = slot. It addresses register (base + i / SLICES) mod NREG at slice i mod SLICES, so groups span consecutive registers and wrap at NREG.
- R6: When a widening flag is set and n >= 2, vs1 and a narrow vs2 are valid only on even slots with index slot/2. A narrow vd is valid only on odd slots with index slot/2. The wide operands map directly. When n = 1, every enabled operand is valid at slot 0 with index 0.
- R7: The memory part length is p = ceil(vl / n). Slot s reports offset s*p and count min(p, vl - s*p). When s*p >= vl it reports offset vl and count 0.
- R8: `sc_rd` pulses only with slot 0 when `issue_sc_src` was set. `sc_wr` pulses only with the writeback of slot n-1 when `issue_sc_dst` was set.
- R9: Each slot reaches the write side (`wb_vld`, `wb_slot`, vd register and slice) DEPTH-1 cycles after the read side. `retire` pulses with slot n-1 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Issue request |
| issue_lmul | input | 3 | Signed log2 of group multiplier |
| issue_wide_vd | input | 1 | Destination is the wide operand |
| issue_wide_vs2 | input | 1 | Source vs2 is a wide operand |
| issue_vs1_en | input | 1 | vs1 is a vector operand |
| issue_vs2_en | input | 1 | vs2 is a vector operand |
| issue_vd_en | input | 1 | vd is a vector operand |
| issue_vs1 | input | 5 | vs1 base register |
| issue_vs2 | input | 5 | vs2 base register |
| issue_vd | input | 5 | vd base register |
| issue_sc_src | input | 1 | Instruction reads a scalar register |
| issue_sc_dst | input | 1 | Instruction writes a scalar register |
| issue_vl | input | 8 | Element count for memory slicing |
| issue_ready | output | 1 | Request can be accepted |
| rd_ok | input | 1 | Reads of the next slot are permitted |
| rd_vld | output | 1 | A slot is at pipeline stage 0 |
| rd_slot | output | 6 | Slot number at stage 0 |
| rd_last | output | 1 | Stage 0 holds the final slot |
| vs1_vld | output | 1 | vs1 is read this slot |
| vs1_reg | output | 5 | vs1 register to read |
| vs1_sl | output | 2 | vs1 slice to read |
| vs2_vld | output | 1 | vs2 is read this slot |
| vs2_reg | output | 5 | vs2 register to read |
| vs2_sl | output | 2 | vs2 slice to read |
| mem_off | output | 8 | First element of this slot |
| mem_cnt | output | 8 | Element count of this slot |
| sc_rd | output | 1 | Scalar source read strobe |
| wb_vld | output | 1 | A slot is at the pipeline tail |
| wb_slot | output | 6 | Slot number at the tail |
| wb_vd_vld | output | 1 | vd is written this slot |
| wb_vd_reg | output | 5 | vd register to write |
| wb_vd_sl | output | 2 | vd slice to write |
| sc_wr | output | 1 | Scalar destination write strobe |
| retire | output | 1 | Final slot written back |

## Verification
The slot walk is run across a set of instruction shapes, each of which separates one mapping rule from the others. Plain integer and fractional multipliers check the slot count and the direct mapping. Destination-widening shapes check the even/odd interleave and the wrap of a 64-slot group past the last register. A widening case with a single slot checks that the interleave is dropped. A source-widening shape checks that a wide vs2 stays on direct mapping while vs1 interleaves. Element counts that do not divide evenly check the clipped and empty memory parts. Directed runs deny `rd_ok` while an instruction is in flight and offer a request that must be ignored, and they compare the ready timing of the pipelined and non-pipelined variants.

// File: rtl/vslice_seq.sv
module vslice_seq #(
  parameter int SLICES    = 4,
  parameter int NREG      = 32,
  parameter int DEPTH     = 3,
  parameter int VLW       = 8,
  parameter int PIPELINED = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_vld,
  input  logic [2:0]                issue_lmul,
  input  logic                      issue_wide_vd,
  input  logic                      issue_wide_vs2,
  input  logic                      issue_vs1_en,
  input  logic                      issue_vs2_en,
  input  logic                      issue_vd_en,
  input  logic [$clog2(NREG)-1:0]   issue_vs1,
  input  logic [$clog2(NREG)-1:0]   issue_vs2,
  input  logic [$clog2(NREG)-1:0]   issue_vd,
  input  logic                      issue_sc_src,
  input  logic                      issue_sc_dst,
  input  logic [VLW-1:0]            issue_vl,
  output logic                      issue_ready,
  input  logic                      rd_ok,
  output logic                      rd_vld,
  output logic [$clog2(SLICES)+3:0] rd_slot,
  output logic                      rd_last,
  output logic                      vs1_vld,
  output logic [$clog2(NREG)-1:0]   vs1_reg,
  output logic [$clog2(SLICES)-1:0] vs1_sl,
  output logic                      vs2_vld,
  output logic [$clog2(NREG)-1:0]   vs2_reg,
  output logic [$clog2(SLICES)-1:0] vs2_sl,
  output logic [VLW-1:0]            mem_off,
  output logic [VLW-1:0]            mem_cnt,
  output logic                      sc_rd,
  output logic                      wb_vld,
  output logic [$clog2(SLICES)+3:0] wb_slot,
  output logic                      wb_vd_vld,
  output logic [$clog2(NREG)-1:0]   wb_vd_reg,
  output logic [$clog2(SLICES)-1:0] wb_vd_sl,
  output logic                      sc_wr,
  output logic                      retire
);
  localparam int LG_S = $clog2(SLICES);
  localparam int RW   = $clog2(NREG);
  localparam int SW   = LG_S + 4;
  localparam int NW   = SW + 1;
  localparam int OW   = VLW + SW;
  localparam int T    = DEPTH - 1;

  function automatic logic [RW-1:0] rmap(input logic [RW-1:0] base, input logic [SW-1:0] idx);
    return base + RW'(idx >> LG_S);
  endfunction

  // issue-side decode
  logic          wide_any, accept;
  logic [4:0]    lsum;
  logic [3:0]    i_lgn;
  logic [NW-1:0] i_n;
  logic [VLW-1:0] i_part;
  assign wide_any = issue_wide_vd | issue_wide_vs2;
  assign lsum     = {{2{issue_lmul[2]}}, issue_lmul} + {4'd0, wide_any} + 5'(LG_S);
  assign i_lgn    = lsum[4] ? 4'd0 : lsum[3:0];
  assign i_n      = NW'(1) << i_lgn;
  assign i_part   = VLW'(((VLW+1)'(issue_vl) + (VLW+1)'(i_n - NW'(1))) >> i_lgn);
  assign accept   = issue_vld & issue_ready;

  // held instruction
  logic           busy;
  logic [SW-1:0]  nxt;
  logic [3:0]     h_lgn;
  logic           h_wv, h_ws, h_e1, h_e2, h_ed, h_scs, h_scd;
  logic [RW-1:0]  h_b1, h_b2, h_bd;
  logic [VLW-1:0] h_vl, h_part;
  logic [NW-1:0]  h_n;
  logic [SW-1:0]  h_lastslot;
  assign h_n        = NW'(1) << h_lgn;
  assign h_lastslot = SW'(h_n - NW'(1));

  // stage 0
  logic          s0_vld;
  logic [SW-1:0] s0_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; nxt <= '0; s0_vld <= 1'b0; s0_slot <= '0;
      h_lgn <= '0; h_wv <= 1'b0; h_ws <= 1'b0; h_e1 <= 1'b0; h_e2 <= 1'b0;
      h_ed <= 1'b0; h_scs <= 1'b0; h_scd <= 1'b0;
      h_b1 <= '0; h_b2 <= '0; h_bd <= '0; h_vl <= '0; h_part <= '0;
    end else if (accept) begin
      busy <= (i_lgn != 4'd0); nxt <= SW'(1);
      s0_vld <= 1'b1; s0_slot <= '0;
      h_lgn <= i_lgn; h_wv <= issue_wide_vd; h_ws <= issue_wide_vs2;
      h_e1 <= issue_vs1_en; h_e2 <= issue_vs2_en; h_ed <= issue_vd_en;
      h_scs <= issue_sc_src; h_scd <= issue_sc_dst;
      h_b1 <= issue_vs1; h_b2 <= issue_vs2; h_bd <= issue_vd;
      h_vl <= issue_vl; h_part <= i_part;
    end else if (busy && rd_ok) begin
      s0_vld <= 1'b1; s0_slot <= nxt;
      nxt <= nxt + SW'(1);
      if (nxt == h_lastslot) busy <= 1'b0;
    end else begin
      s0_vld <= 1'b0;
    end
  end

  // operand mapping at stage 0
  logic          il, n2, nd, s0_last, d_vld;
  logic [SW-1:0] half, i1, i2, id;
  assign il      = (h_wv | h_ws) && (h_lgn != 4'd0);
  assign n2      = il & ~h_ws;
  assign nd      = il & ~h_wv;
  assign half    = s0_slot >> 1;
  assign i1      = il ? half : s0_slot;
  assign i2      = n2 ? half : s0_slot;
  assign id      = nd ? half : s0_slot;
  assign s0_last = s0_slot == h_lastslot;
  assign d_vld   = s0_vld & h_ed & (~nd | s0_slot[0]);

  assign rd_vld  = s0_vld;
  assign rd_slot = s0_slot;
  assign rd_last = s0_vld & s0_last;
  assign vs1_vld = s0_vld & h_e1 & (~il | ~s0_slot[0]);
  assign vs1_reg = rmap(h_b1, i1);
  assign vs1_sl  = i1[LG_S-1:0];
  assign vs2_vld = s0_vld & h_e2 & (~n2 | ~s0_slot[0]);
  assign vs2_reg = rmap(h_b2, i2);
  assign vs2_sl  = i2[LG_S-1:0];
  assign sc_rd   = s0_vld & h_scs & (s0_slot == '0);

  // memory slicing
  logic [OW-1:0]  off_full;
  logic [VLW-1:0] rem;
  logic           past_end;
  assign off_full = OW'(s0_slot) * OW'(h_part);
  assign past_end = off_full >= OW'(h_vl);
  assign mem_off  = past_end ? h_vl : off_full[VLW-1:0];
  assign rem      = h_vl - mem_off;
  assign mem_cnt  = past_end ? '0 : ((h_part < rem) ? h_part : rem);

  // pipeline stages 1..DEPTH-1 (DEPTH >= 2)
  logic [DEPTH-1:1] pv, pl, pdv, psc;
  logic [SW-1:0]    ps  [DEPTH-1:1];
  logic [RW-1:0]    pdr [DEPTH-1:1];
  logic [LG_S-1:0]  pds [DEPTH-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0; pl <= '0; pdv <= '0; psc <= '0;
      for (int i = 1; i < DEPTH; i++) begin
        ps[i] <= '0; pdr[i] <= '0; pds[i] <= '0;
      end
    end else begin
      pv[1] <= s0_vld; pl[1] <= s0_last; pdv[1] <= d_vld; psc[1] <= h_scd;
      ps[1] <= s0_slot; pdr[1] <= rmap(h_bd, id); pds[1] <= id[LG_S-1:0];
      for (int i = 2; i < DEPTH; i++) begin
        pv[i] <= pv[i-1]; pl[i] <= pl[i-1]; pdv[i] <= pdv[i-1]; psc[i] <= psc[i-1];
        ps[i] <= ps[i-1]; pdr[i] <= pdr[i-1]; pds[i] <= pds[i-1];
      end
    end
  end

  assign wb_vld    = pv[T];
  assign wb_slot   = ps[T];
  assign wb_vd_vld = pv[T] & pdv[T];
  assign wb_vd_reg = pdr[T];
  assign wb_vd_sl  = pds[T];
  assign retire    = pv[T] & pl[T];
  assign sc_wr     = pv[T] & pl[T] & psc[T];

  assign issue_ready = ~busy & ((PIPELINED != 0) | ~(s0_vld | (|pv)));

  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rd_vld && rd_slot == '0));
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_ok && nxt == h_lastslot) |=> (!busy && rd_last));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_ok) |=> !rd_vld);
  p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> (NW'(rd_slot) < h_n));
  p_scalar_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rd |-> $past(accept));
endmodule

// File: tb/vslice_seq_tb.sv
`timescale 1ns/1ps
module vslice_seq_tb_top;
  localparam int SLICES = 4;
  localparam int DEPTH  = 3;
  localparam logic [4:0] B1 = 5'd2, B2 = 5'd10, BD = 5'd20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       issue_vld = 1'b0, rd_ok = 1'b1;
  logic [2:0] issue_lmul = '0;
  logic       issue_wide_vd = 1'b0, issue_wide_vs2 = 1'b0;
  logic       issue_sc_src = 1'b0, issue_sc_dst = 1'b0;
  logic [7:0] issue_vl = '0;
  logic       issue_ready, rd_vld, rd_last, vs1_vld, vs2_vld, sc_rd;
  logic [5:0] rd_slot, wb_slot;
  logic [4:0] vs1_reg, vs2_reg, wb_vd_reg;
  logic [1:0] vs1_sl, vs2_sl, wb_vd_sl;
  logic [7:0] mem_off, mem_cnt;
  logic       wb_vld, wb_vd_vld, sc_wr, retire;
  logic       np_ready;
  logic       np_rd_vld, np_rd_last, np_v1, np_v2, np_scr, np_wbv, np_wdv, np_scw, np_ret;
  logic [5:0] np_rs, np_ws;
  logic [4:0] np_r1, np_r2, np_rd;
  logic [1:0] np_s1, np_s2, np_sd;
  logic [7:0] np_mo, np_mc;

  vslice_seq dut_i (
    .clk, .rst_n, .issue_vld, .issue_lmul, .issue_wide_vd, .issue_wide_vs2,
    .issue_vs1_en(1'b1), .issue_vs2_en(1'b1), .issue_vd_en(1'b1),
    .issue_vs1(B1), .issue_vs2(B2), .issue_vd(BD),
    .issue_sc_src, .issue_sc_dst, .issue_vl, .issue_ready, .rd_ok,
    .rd_vld, .rd_slot, .rd_last, .vs1_vld, .vs1_reg, .vs1_sl,
    .vs2_vld, .vs2_reg, .vs2_sl, .mem_off, .mem_cnt, .sc_rd,
    .wb_vld, .wb_slot, .wb_vd_vld, .wb_vd_reg, .wb_vd_sl, .sc_wr, .retire);

  vslice_seq #(.PIPELINED(0)) dut_np (
    .clk, .rst_n, .issue_vld, .issue_lmul, .issue_wide_vd, .issue_wide_vs2,
    .issue_vs1_en(1'b1), .issue_vs2_en(1'b1), .issue_vd_en(1'b1),
    .issue_vs1(B1), .issue_vs2(B2), .issue_vd(BD),
    .issue_sc_src, .issue_sc_dst, .issue_vl, .issue_ready(np_ready), .rd_ok,
    .rd_vld(np_rd_vld), .rd_slot(np_rs), .rd_last(np_rd_last),
    .vs1_vld(np_v1), .vs1_reg(np_r1), .vs1_sl(np_s1),
    .vs2_vld(np_v2), .vs2_reg(np_r2), .vs2_sl(np_s2),
    .mem_off(np_mo), .mem_cnt(np_mc), .sc_rd(np_scr),
    .wb_vld(np_wbv), .wb_slot(np_ws), .wb_vd_vld(np_wdv), .wb_vd_reg(np_rd),
    .wb_vd_sl(np_sd), .sc_wr(np_scw), .retire(np_ret));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ll, wide_vd, wide_vs2, vl, sc_src, sc_dst, expected slot count (R1)
  localparam logic [21:0] TBL [9] = '{
    {3'd0, 1'b0, 1'b0, 8'd16,  1'b1, 1'b1, 7'd4},
    {3'd1, 1'b0, 1'b0, 8'd20,  1'b0, 1'b0, 7'd8},
    {3'd6, 1'b0, 1'b0, 8'd3,   1'b1, 1'b0, 7'd1},
    {3'd0, 1'b1, 1'b0, 8'd16,  1'b0, 1'b1, 7'd8},
    {3'd6, 1'b1, 1'b0, 8'd5,   1'b0, 1'b0, 7'd2},
    {3'd5, 1'b1, 1'b0, 8'd2,   1'b0, 1'b1, 7'd1},
    {3'd1, 1'b0, 1'b1, 8'd40,  1'b1, 1'b1, 7'd16},
    {3'd3, 1'b1, 1'b0, 8'd255, 1'b0, 1'b1, 7'd64},
    {3'd4, 1'b0, 1'b1, 8'd7,   1'b0, 1'b0, 7'd1}
  };

  bit c_wv, c_ws, c_scs, c_scd;
  int c_vl, c_n;

  function automatic logic [40:0] exp_rd(input int s);
    int lg; bit il, n2, v1, v2; int i1, i2, part, off, cnt;
    lg = $clog2(c_n);
    il = (c_wv || c_ws) && lg > 0;
    n2 = il && !c_ws;
    v1 = il ? (s % 2 == 0) : 1'b1;  i1 = il ? s / 2 : s;
    v2 = n2 ? (s % 2 == 0) : 1'b1;  i2 = n2 ? s / 2 : s;
    part = (c_vl + c_n - 1) / c_n;
    off = s * part;
    if (off >= c_vl) begin off = c_vl; cnt = 0; end
    else cnt = (part < c_vl - off) ? part : c_vl - off;
    return {1'b1, 6'(s), s == c_n - 1,
            v1, v1 ? 5'((B1 + i1 / SLICES) % 32) : 5'd0, v1 ? 2'(i1 % SLICES) : 2'd0,
            v2, v2 ? 5'((B2 + i2 / SLICES) % 32) : 5'd0, v2 ? 2'(i2 % SLICES) : 2'd0,
            8'(off), 8'(cnt), (s == 0) && c_scs};
  endfunction

  function automatic logic [16:0] exp_wr(input int s);
    int lg; bit nd, dv; int id;
    lg = $clog2(c_n);
    nd = (c_wv || c_ws) && lg > 0 && !c_wv;
    dv = nd ? (s % 2 == 1) : 1'b1;
    id = nd ? s / 2 : s;
    return {1'b1, 6'(s), s == c_n - 1, dv,
            dv ? 5'((BD + id / SLICES) % 32) : 5'd0, dv ? 2'(id % SLICES) : 2'd0,
            (s == c_n - 1) && c_scd};
  endfunction

  function automatic logic [40:0] act_rd();
    return {rd_vld, rd_slot, rd_last,
            vs1_vld, vs1_vld ? vs1_reg : 5'd0, vs1_vld ? vs1_sl : 2'd0,
            vs2_vld, vs2_vld ? vs2_reg : 5'd0, vs2_vld ? vs2_sl : 2'd0,
            mem_off, mem_cnt, sc_rd};
  endfunction

  function automatic logic [16:0] act_wr();
    return {wb_vld, wb_slot, retire, wb_vd_vld,
            wb_vd_vld ? wb_vd_reg : 5'd0, wb_vd_vld ? wb_vd_sl : 2'd0, sc_wr};
  endfunction

  task automatic start(input logic [21:0] e);
    c_wv = e[18]; c_ws = e[17]; c_vl = int'(e[16:9]);
    c_scs = e[8]; c_scd = e[7]; c_n = int'(e[6:0]);
    @(negedge clk);
    issue_lmul = e[21:19]; issue_wide_vd = e[18]; issue_wide_vs2 = e[17];
    issue_vl = e[16:9]; issue_sc_src = e[8]; issue_sc_dst = e[7];
    issue_vld = 1'b1;
    @(posedge clk); @(negedge clk);
    issue_vld = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(issue_ready == 1'b1 && rd_vld == 1'b0, "R3 reset ready/idle", {issue_ready, rd_vld}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk({issue_ready, rd_vld, wb_vld, retire} == 4'b1000, "R3 after reset",
        {issue_ready, rd_vld, wb_vld, retire}, 4'b1000);

    // R4: non-pipelined ready waits for an empty pipeline
    start(TBL[2]);
    chk(issue_ready == 1'b1, "R4 pipelined ready after one-slot issue", issue_ready, 1);
    chk(np_ready == 1'b0, "R4 non-pipelined ready k=0", np_ready, 0);
    for (int k = 1; k <= 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(np_ready == (k == 3), "R4 non-pipelined ready drain", np_ready, 64'(k == 3));
    end
    repeat (2) @(posedge clk);

    // table walk: R1 R2 R5 R6 R7 R8 R9
    for (int t = 0; t < 9; t++) begin
      start(TBL[t]);
      for (int c = 0; c < c_n + DEPTH - 1; c++) begin
        if (c < c_n) begin
          chk(act_rd() == exp_rd(c), "R1 R2 R5 R6 R7 R8 read slot", act_rd(), exp_rd(c));
          if (c < c_n - 1)
            chk(issue_ready == 1'b0, "R3 ready low while slots remain", issue_ready, 0);
        end else
          chk(rd_vld == 1'b0, "R2 nothing after last slot", rd_vld, 0);
        if (c >= DEPTH - 1)
          chk(act_wr() == exp_wr(c - DEPTH + 1), "R9 R8 writeback slot", act_wr(), exp_wr(c - DEPTH + 1));
        @(posedge clk); @(negedge clk);
      end
      chk({retire, issue_ready} == 2'b01, "R9 single retire", {retire, issue_ready}, 2'b01);
    end

    // R3: denied reads stall injection, a request while busy is ignored
    c_wv = 0; c_ws = 0; c_vl = 16; c_scs = 0; c_scd = 0; c_n = 4;
    @(negedge clk);
    issue_lmul = 3'd0; issue_wide_vd = 0; issue_wide_vs2 = 0; issue_vl = 8'd16;
    issue_sc_src = 0; issue_sc_dst = 0; issue_vld = 1'b1; rd_ok = 1'b0;
    @(posedge clk); @(negedge clk);
    issue_vld = 1'b0;
    chk(act_rd() == exp_rd(0), "R3 slot0 enters without permission", act_rd(), exp_rd(0));
    issue_lmul = 3'd3; issue_sc_src = 1'b1; issue_vl = 8'd99; issue_vld = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(rd_vld == 1'b0, "R3 no slot while rd_ok low", rd_vld, 0);
      chk(issue_ready == 1'b0, "R3 ready low during stall", issue_ready, 0);
    end
    issue_vld = 1'b0; rd_ok = 1'b1;
    for (int s = 1; s < 4; s++) begin
      @(posedge clk); @(negedge clk);
      chk(act_rd() == exp_rd(s), "R3 resume after stall", act_rd(), exp_rd(s));
    end
    @(posedge clk); @(negedge clk);
    chk({rd_vld, issue_ready} == 2'b01, "R3 ignored request left no slot",
        {rd_vld, issue_ready}, 2'b01);
    repeat (DEPTH + 2) @(posedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule